// File: doc/BRIEF.md
# Selectable Sync Character Hunter

This block hunts for character framing on a group of synchronous serial receive lines. Each lane shifts in received bits on its own bit-clock enable, least significant bit first. While hunting, it compares the most recent N bits against one of two sync codes after every bit. The two codes are shared by the whole group, and each lane picks one of them. The character length N is 5, 6, 7 or 8 bits and is set per lane.

A lane declares framing either on a single sync character or on two identical sync characters back to back, chosen per lane. Once framed, the lane cuts the bit stream into characters of N data bits. When parity is enabled, one parity bit follows each character. Every character is delivered with a one-cycle valid pulse and a parity error flag. Sync characters received after framing can be dropped instead of delivered. A resync strobe sends a lane back to hunting. Each lane has its own locked output that shows whether it is framed.

Top module: `sync_hunt_group`

## Requirements
- R1: After reset, every lane is unlocked (`locked_o` low) and `chr_valid_o` is low.
- R2: While hunting, a lane compares on every enabled bit. The window is the last N received bits, taken with the first-received bit as bit 0, and it is compared with the low N bits of the selected code: `code_a_i` when `code_sel_i` is 0, `code_b_i` when it is 1. A window that matches only the unselected code does not lock the lane.
- R3: In single-sync mode (`two_sync_i` = 0), the lane locks on the clock edge that samples the bit completing a matching window. The sync characters that establish framing are never delivered as data.
- R4: In double-sync mode (`two_sync_i` = 1), a first match alone leaves the lane unlocked. The lane locks only if the window again matches exactly N bits later. Otherwise it returns to hunting, and the comparison continues on every following bit.
- R5: The character length encoding is `char_len_i` 0→5, 1→6, 2→7, 3→8 bits. Once framed, each character is N data bits, LSB first, delivered right-justified on `chr_data_o` with the upper bits zero, in arrival order.
- R6: The parity encoding is `par_mode_i` 0 = none, 1 = even, 2 = odd, 3 = none. With parity enabled, one parity bit follows each character's data bits. `par_err_o` is 1 when the number of ones in the data bits plus the parity bit is odd in even mode, or even in odd mode.
- R7: When `strip_en_i` = 1, a framed character equal to the selected code is not delivered. When `strip_en_i` = 0, such a character is delivered like any other character.
- R8: A resync pulse unlocks the lane from the next edge onward, and the lane returns to hunting. No character is delivered until the lane locks again.
- R9: Lanes are independent. Stimulus, resync and configuration on one lane do not change another lane's lock state or characters.
- R10: `chr_valid_o` is a single-cycle pulse that follows the edge sampling a character's last bit (the parity bit when parity is enabled, otherwise the last data bit). It never appears while the lane is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_a_i | input | 8 | First group-shared sync code |
| code_b_i | input | 8 | Second group-shared sync code |
| bit_en_i | input | LINES | Per-lane bit-clock enable |
| rx_bit_i | input | LINES | Per-lane serial data |
| resync_i | input | LINES | Per-lane return-to-hunt strobe |
| code_sel_i | input | LINES | Per-lane sync code choice |
| two_sync_i | input | LINES | Per-lane double-sync lock rule |
| strip_en_i | input | LINES | Per-lane post-framing sync removal |
| char_len_i | input | 2*LINES | Per-lane length code |
| par_mode_i | input | 2*LINES | Per-lane parity code |
| chr_valid_o | output | LINES | Per-lane character pulse |
| chr_data_o | output | 8*LINES | Per-lane character, right-justified |
| par_err_o | output | LINES | Per-lane parity error with the character |
| locked_o | output | LINES | Per-lane framed state |

## Verification
The hardest case to reach is a failed double-sync lock: the lane must see one sync, then a character that is not a sync exactly one length later, and only then two good syncs. The stimulus builds exactly that sequence. It checks that the lane stays unlocked after the failed attempt and after the first good sync, and locks only on the second one. A preamble of ones comes before each sync. Because every sync code used has bit 0 clear, no partial window can match by accident, so the cycle where the lock edge occurs is fully predictable.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_SECOND = 2'd1,
    ST_FRAMED = 2'd2
  } lane_state_e;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;
endpackage

// File: rtl/char_align.sv
module char_align #(
  parameter int CW = 8,
  localparam int CNT_W = $clog2(CW + 1)
) (
  input  logic [CW-1:0]    sr_next,
  input  logic [CNT_W-1:0] nbits,
  output logic [CW-1:0]    win
);
  logic [CNT_W-1:0] shamt;
  always_comb begin
    shamt = CNT_W'(CW) - nbits;
    win   = sr_next >> shamt;
  end
endmodule

// File: rtl/sync_cmp.sv
module sync_cmp #(
  parameter int CW = 8,
  localparam int CNT_W = $clog2(CW + 1)
) (
  input  logic [CW-1:0]    win,
  input  logic [CW-1:0]    code,
  input  logic [CNT_W-1:0] nbits,
  output logic             hit
);
  logic [CW-1:0] mask;
  for (genvar i = 0; i < CW; i++) begin : g_mask
    assign mask[i] = (CNT_W'(i) < nbits);
  end
  assign hit = (((win ^ code) & mask) == '0);
endmodule

// File: rtl/par_check.sv
module par_check import sync_hunt_pkg::*; #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] data,
  input  logic          pbit,
  input  logic [1:0]    mode,
  output logic          err
);
  logic ones_odd;
  always_comb begin
    ones_odd = (^data) ^ pbit;
    if (mode == PAR_EVEN)     err = ones_odd;
    else if (mode == PAR_ODD) err = ~ones_odd;
    else                      err = 1'b0;
  end
endmodule

// File: rtl/sync_lane.sv
module sync_lane import sync_hunt_pkg::*; #(
  parameter int CW = 8,
  localparam int CNT_W = $clog2(CW + 1),
  localparam int MIN_LEN = CW - 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          rx_bit,
  input  logic          resync,
  input  logic [CW-1:0] code_a,
  input  logic [CW-1:0] code_b,
  input  logic          code_sel,
  input  logic          two_sync,
  input  logic          strip_en,
  input  logic [1:0]    len_enc,
  input  logic [1:0]    par_mode,
  output logic          chr_valid,
  output logic [CW-1:0] chr_data,
  output logic          par_err,
  output logic          locked
);
  lane_state_e      state;
  logic [CW-1:0]    sr, sr_next, win, code, hold;
  logic [CNT_W-1:0] nbits, cnt, fill;
  logic             hit, in_par, hold_sync, par_on, perr_w, fill_ok;

  always_comb begin
    nbits   = CNT_W'(MIN_LEN) + CNT_W'(len_enc);
    sr_next = {rx_bit, sr[CW-1:1]};
    code    = code_sel ? code_b : code_a;
    par_on  = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
    fill_ok = (fill >= nbits - CNT_W'(1));
  end

  char_align #(.CW(CW)) u_align (.sr_next(sr_next), .nbits(nbits), .win(win));
  sync_cmp   #(.CW(CW)) u_cmp   (.win(win), .code(code), .nbits(nbits), .hit(hit));
  par_check  #(.CW(CW)) u_par   (.data(hold), .pbit(rx_bit), .mode(par_mode), .err(perr_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HUNT;
      sr        <= '0;
      cnt       <= '0;
      fill      <= '0;
      hold      <= '0;
      hold_sync <= 1'b0;
      in_par    <= 1'b0;
      chr_valid <= 1'b0;
      chr_data  <= '0;
      par_err   <= 1'b0;
    end else begin
      chr_valid <= 1'b0;
      if (resync) begin
        state  <= ST_HUNT;
        fill   <= '0;
        cnt    <= '0;
        in_par <= 1'b0;
      end else if (bit_en) begin
        sr <= sr_next;
        unique case (state)
          ST_HUNT: begin
            if (fill < nbits) fill <= fill + CNT_W'(1);
            if (fill_ok && hit) begin
              cnt    <= '0;
              in_par <= 1'b0;
              state  <= two_sync ? ST_SECOND : ST_FRAMED;
            end
          end
          ST_SECOND: begin
            if (cnt == nbits - CNT_W'(1)) begin
              cnt <= '0;
              if (hit) state <= ST_FRAMED;
              else begin
                state <= ST_HUNT;
                fill  <= nbits;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_FRAMED: begin
            if (in_par) begin
              in_par <= 1'b0;
              cnt    <= '0;
              if (!(strip_en && hold_sync)) begin
                chr_valid <= 1'b1;
                chr_data  <= hold;
                par_err   <= perr_w;
              end
            end else if (cnt == nbits - CNT_W'(1)) begin
              cnt <= '0;
              if (par_on) begin
                hold      <= win;
                hold_sync <= hit;
                in_par    <= 1'b1;
              end else if (!(strip_en && hit)) begin
                chr_valid <= 1'b1;
                chr_data  <= win;
                par_err   <= 1'b0;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  assign locked = (state == ST_FRAMED);

  a_r10_valid_only_locked: assert property (@(posedge clk) disable iff (rst)
    chr_valid |-> locked);
  a_r10_valid_after_bit: assert property (@(posedge clk) disable iff (rst)
    chr_valid |-> $past(bit_en));
  a_r8_resync_unlocks: assert property (@(posedge clk) disable iff (rst)
    resync |=> (!locked && !chr_valid));
  a_r3_lock_on_bit: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(bit_en));
  a_r4_two_sync_path: assert property (@(posedge clk) disable iff (rst)
    ($rose(locked) && $past(two_sync)) |-> $past(state == ST_SECOND));
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(CW));
endmodule

// File: rtl/sync_hunt_group.sv
module sync_hunt_group #(
  parameter int LINES = 4,
  parameter int CW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CW-1:0]       code_a_i,
  input  logic [CW-1:0]       code_b_i,
  input  logic [LINES-1:0]    bit_en_i,
  input  logic [LINES-1:0]    rx_bit_i,
  input  logic [LINES-1:0]    resync_i,
  input  logic [LINES-1:0]    code_sel_i,
  input  logic [LINES-1:0]    two_sync_i,
  input  logic [LINES-1:0]    strip_en_i,
  input  logic [2*LINES-1:0]  char_len_i,
  input  logic [2*LINES-1:0]  par_mode_i,
  output logic [LINES-1:0]    chr_valid_o,
  output logic [CW*LINES-1:0] chr_data_o,
  output logic [LINES-1:0]    par_err_o,
  output logic [LINES-1:0]    locked_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_lane
    sync_lane #(.CW(CW)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .bit_en    (bit_en_i[l]),
      .rx_bit    (rx_bit_i[l]),
      .resync    (resync_i[l]),
      .code_a    (code_a_i),
      .code_b    (code_b_i),
      .code_sel  (code_sel_i[l]),
      .two_sync  (two_sync_i[l]),
      .strip_en  (strip_en_i[l]),
      .len_enc   (char_len_i[2*l +: 2]),
      .par_mode  (par_mode_i[2*l +: 2]),
      .chr_valid (chr_valid_o[l]),
      .chr_data  (chr_data_o[CW*l +: CW]),
      .par_err   (par_err_o[l]),
      .locked    (locked_o[l])
    );
  end
endmodule

// File: tb/sim_sync_hunt_group.sv
module sim_sync_hunt_group;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] code_a = 8'h16, code_b = 8'h32;
  logic [LINES-1:0] bit_en = '0, rx_bit = '0, resync = '0;
  logic [LINES-1:0] code_sel = 4'b0010, two_sync = 4'b0001, strip_en = 4'b0100;
  logic [2*LINES-1:0] char_len = {2'd0, 2'd2, 2'd3, 2'd3};
  logic [2*LINES-1:0] par_mode = {2'd2, 2'd1, 2'd0, 2'd0};
  logic [LINES-1:0] chr_valid, par_err, locked;
  logic [CW*LINES-1:0] chr_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [10:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_hunt_group #(.LINES(LINES), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .code_a_i(code_a), .code_b_i(code_b),
    .bit_en_i(bit_en), .rx_bit_i(rx_bit), .resync_i(resync),
    .code_sel_i(code_sel), .two_sync_i(two_sync), .strip_en_i(strip_en),
    .char_len_i(char_len), .par_mode_i(par_mode),
    .chr_valid_o(chr_valid), .chr_data_o(chr_data),
    .par_err_o(par_err), .locked_o(locked)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input int l, input logic b);
    rx_bit[l] = b;
    bit_en[l] = 1'b1;
    @(negedge clk);
    bit_en[l] = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_ones(input int l, input int k);
    for (int i = 0; i < k; i++) send_bit(l, 1'b1);
  endtask

  // pm: 0 none, 1 even, 2 odd; bad flips the parity bit
  task automatic send_val(input int l, input logic [7:0] v, input int n,
                          input int pm, input bit bad);
    logic p;
    logic [7:0] m;
    m = v & 8'((1 << n) - 1);
    for (int i = 0; i < n; i++) send_bit(l, m[i]);
    if (pm == 1 || pm == 2) begin
      p = (pm == 1) ? ^m : ~^m;
      if (bad) p = ~p;
      send_bit(l, p);
    end
  endtask

  task automatic expect_chr(input int l, input logic [7:0] v, input bit perr);
    exp_q.push_back({2'(l), perr, v});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int l = 0; l < LINES; l++) begin
        if (chr_valid[l]) begin
          logic [10:0] act, exp;
          act = {2'(l), par_err[l], chr_data[CW*l +: CW]};
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected character", int'(act), 0);
          end else begin
            exp = exp_q.pop_front();
            check(act == exp, "R5/R6/R7 character stream", int'(act), int'(exp));
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(locked == 4'b0000, "R1 locked after reset", int'(locked), 0);
    check(chr_valid == 4'b0000, "R1 valid after reset", int'(chr_valid), 0);

    // lane 0: double-sync, 8 bits, no parity, no strip
    send_ones(0, 8);
    send_val(0, 8'h16, 8, 0, 0);
    check(locked[0] == 1'b0, "R4 single sync does not lock", int'(locked[0]), 0);
    send_val(0, 8'hFF, 8, 0, 0);
    check(locked[0] == 1'b0, "R4 failed second sync", int'(locked[0]), 0);
    send_ones(0, 4);
    send_val(0, 8'h16, 8, 0, 0);
    check(locked[0] == 1'b0, "R4 first of pair", int'(locked[0]), 0);
    send_val(0, 8'h16, 8, 0, 0);
    check(locked[0] == 1'b1, "R4 R10 lock on second sync", int'(locked[0]), 1);
    expect_chr(0, 8'h41, 0); send_val(0, 8'h41, 8, 0, 0);
    expect_chr(0, 8'h16, 0); send_val(0, 8'h16, 8, 0, 0); // R7 kept when strip off
    expect_chr(0, 8'h00, 0); send_val(0, 8'h00, 8, 0, 0);
    resync[0] = 1'b1; @(negedge clk); resync[0] = 1'b0;
    check(locked[0] == 1'b0, "R8 resync unlocks", int'(locked[0]), 0);
    send_val(0, 8'hAA, 8, 0, 0);
    send_val(0, 8'hFF, 8, 0, 0);
    check(locked[0] == 1'b0, "R8 stays hunting", int'(locked[0]), 0);
    send_val(0, 8'h16, 8, 0, 0);
    send_val(0, 8'h16, 8, 0, 0);
    check(locked[0] == 1'b1, "R8 relock", int'(locked[0]), 1);
    expect_chr(0, 8'h5A, 0); send_val(0, 8'h5A, 8, 0, 0);

    // lane 1: code select picks code_b
    send_ones(1, 8);
    send_val(1, 8'h16, 8, 0, 0);
    check(locked[1] == 1'b0, "R2 unselected code ignored", int'(locked[1]), 0);
    send_val(1, 8'h32, 8, 0, 0);
    check(locked[1] == 1'b1, "R2 R3 selected code locks", int'(locked[1]), 1);
    expect_chr(1, 8'hC3, 0); send_val(1, 8'hC3, 8, 0, 0);

    // lane 2: 7 bits, even parity, strip on
    send_ones(2, 8);
    send_val(2, 8'h16, 7, 0, 0);
    check(locked[2] == 1'b1, "R3 R5 seven-bit lock", int'(locked[2]), 1);
    expect_chr(2, 8'h35, 0); send_val(2, 8'h35, 7, 1, 0);
    send_val(2, 8'h16, 7, 1, 0); // R7 stripped
    expect_chr(2, 8'h7F, 1); send_val(2, 8'h7F, 7, 1, 1); // R6 bad parity
    expect_chr(2, 8'h01, 0); send_val(2, 8'h01, 7, 1, 0);

    // lane 3: 5 bits, odd parity
    send_ones(3, 8);
    send_val(3, 8'h16, 5, 0, 0);
    check(locked[3] == 1'b1, "R5 five-bit lock", int'(locked[3]), 1);
    expect_chr(3, 8'h0B, 0); send_val(3, 8'h0B, 5, 2, 0);
    expect_chr(3, 8'h1F, 1); send_val(3, 8'h1F, 5, 2, 1); // R6 odd error
    expect_chr(3, 8'h04, 0); send_val(3, 8'h04, 5, 2, 0);

    repeat (4) @(negedge clk);
    check(locked == 4'b1111, "R9 lanes independent", int'(locked), 15);
    check(exp_q.size() == 0, "R5 all characters delivered", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule